// File: doc/BRIEF.md
# Store-multiple descending address sequencer

This block carries out a single store-multiple operation on a full-descending stack. A request names a set of registers through a 16-bit select mask, gives the index of the base register, says whether the base register is to be updated, and supplies the current base value. The block stores one 32-bit word per accepted memory handshake. The first word goes to the base minus four bytes per selected register. Each later word goes four bytes higher than the one before it. Registers are taken in ascending index order. Register values come through a register-file read port. The program counter slot is special: it always takes a separately supplied store value.

When the last word is accepted, the block raises a one-cycle done pulse. If writeback was requested, a writeback strobe fires in the same cycle and the new base value is presented. Requests whose masks are illegal are rejected with a one-cycle error pulse and no memory traffic. The block applies one rule set for the full-width encoding and a stricter rule set for the compact encoding. It also marks stack pushes, and it marks the one case where the stored base value is undefined.

Top module: `stm_desc_seq`

## Requirements
- R1: The first write of a legal request goes to `base_val - 4*popcount(mask)` (modulo 2^32). `base_new` holds the same value from the cycle after the start.
- R2: Selected registers are written in ascending index order, one per accepted handshake (`mem_valid && mem_ready`). Each address is 4 above the previous one. For an ordinary register, `mem_data` is `rf_rdata` read at `rf_raddr` = that register's index.
- R3: `wb_strobe` is high exactly in the done cycle of a request made with `wb_en=1`, and never when `wb_en=0`. In that cycle `base_new` equals the first write address.
- R4: If mask bit 15 (the program counter) is selected, it is the last write, at the highest address, and its data is `pc_store_val`.
- R5: With `compact=0`, `wb_en=1`, `mask[base_idx]=1` and `base_idx` not the lowest set bit, the base register's word is the placeholder 32'hBAD0_BAD0 and `base_unk` is high during that write. If the base register is the lowest set bit, its real value is stored and `base_unk` stays low.
- R6: An empty mask, or `base_idx=15`, gives `err` high for exactly the one cycle after the start, with no `mem_valid`, no `busy`, no `done` and no `wb_strobe`.
- R7: With `compact=1`, a request is also illegal, with the R6 behaviour, if fewer than two bits are set, if bit 13 or bit 15 is set, or if `wb_en=1` and `mask[base_idx]=1`.
- R8: `push_alias` is 1 from the cycle after a legal start through its done cycle exactly when `wb_en=1`, `base_idx=13` and more than one bit is set. It is 0 after an illegal start.
- R9: `busy` is high from the cycle after a legal start until the last write is accepted. `done` is high for exactly the one cycle after that acceptance.
- R10: A `start` while `busy` is high is ignored. This holds even in the cycle in which the last write is accepted: the running sequence is unchanged and no second sequence follows.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid` and `mem_addr` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| mask | input | 16 | Register select mask, bit i selects register i |
| base_idx | input | 4 | Index of the base register |
| wb_en | input | 1 | Update the base register on completion |
| compact | input | 1 | Apply the compact-encoding legality rules |
| base_val | input | 32 | Current base register value |
| pc_store_val | input | 32 | Value stored for register 15 |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data for `rf_raddr` |
| mem_valid | output | 1 | Write request valid |
| mem_addr | output | 32 | Write byte address |
| mem_data | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |
| wb_strobe | output | 1 | Base writeback strobe, coincides with done |
| base_new | output | 32 | Updated base value |
| err | output | 1 | One-cycle illegal-request pulse |
| push_alias | output | 1 | Request is a stack push |
| base_unk | output | 1 | Current write carries the undefined-base placeholder |

## Verification
Two things can happen in the same cycle: a new start request, and the acceptance of the final write of the running sequence. The bench provokes this by pulsing `start` in the first cycle after each legal start. In that cycle a one-register request with an always-ready memory is completing. The pulse carries a different mask and base. The bench judges the outcome from what follows. The writes and the done cycle must match the first request alone, and `mem_valid`, `busy` and `done` must stay low for the cycles after it. The sweep covers many masks, every base index, both writeback settings, both encodings, and both stalled and free-running memory.

// File: rtl/stmd_pkg.sv
package stmd_pkg;
   typedef struct packed {
      logic illegal;
      logic unk_en;
      logic push;
   } stmd_chk_t;
endpackage

// File: rtl/stmd_lsb_pick.sv
module stmd_lsb_pick #(
   parameter int N  = 16,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/stmd_popcnt.sv
module stmd_popcnt #(
   parameter int N  = 16,
   parameter int CW = $clog2(N + 1)
) (
   input  logic [N-1:0]  vec,
   output logic [CW-1:0] cnt
);
   logic [CW-1:0] part [N+1];
   assign part[0] = '0;
   for (genvar g = 0; g < N; g++) begin : g_sum
      assign part[g+1] = part[g] + CW'(vec[g]);
   end
   assign cnt = part[N];
endmodule

// File: rtl/stmd_legal.sv
module stmd_legal
   import stmd_pkg::*;
#(
   parameter int NREG           = 16,
   parameter int IW             = $clog2(NREG),
   parameter int CW             = $clog2(NREG + 1),
   parameter int SP_IDX         = 13,
   parameter bit ENABLE_COMPACT = 1'b1
) (
   input  logic [NREG-1:0] mask,
   input  logic [IW-1:0]   base_idx,
   input  logic            wb,
   input  logic            compact,
   input  logic [CW-1:0]   cnt,
   input  logic [IW-1:0]   low_idx,
   output stmd_chk_t       chk
);
   localparam int PC_IDX = NREG - 1;

   logic base_sel, full_bad, cmp_bad;

   assign base_sel = mask[base_idx];
   assign full_bad = (cnt == '0) || (base_idx == IW'(PC_IDX));

   if (ENABLE_COMPACT) begin : g_cmp
      // compact form: two or more registers, no stack pointer, no PC, no base in list with writeback
      assign cmp_bad = compact && ((cnt < CW'(2)) || mask[SP_IDX] || mask[PC_IDX]
                                   || (wb && base_sel));
   end else begin : g_full_only
      assign cmp_bad = 1'b0;
   end

   always_comb begin
      chk.illegal = full_bad || cmp_bad;
      chk.unk_en  = wb && base_sel && (base_idx != low_idx);
      chk.push    = wb && (base_idx == IW'(SP_IDX)) && (cnt > CW'(1));
   end
endmodule

// File: rtl/stm_desc_seq.sv
module stm_desc_seq
   import stmd_pkg::*;
#(
   parameter int              NREG           = 16,
   parameter int              DW             = 32,
   parameter int              AW             = 32,
   parameter int              SP_IDX         = 13,
   parameter bit              ENABLE_COMPACT = 1'b1,
   parameter logic [DW-1:0]   UNK_WORD       = 32'hBAD0_BAD0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [NREG-1:0]           mask,
   input  logic [$clog2(NREG)-1:0]   base_idx,
   input  logic                      wb_en,
   input  logic                      compact,
   input  logic [AW-1:0]             base_val,
   input  logic [DW-1:0]             pc_store_val,
   output logic [$clog2(NREG)-1:0]   rf_raddr,
   input  logic [DW-1:0]             rf_rdata,
   output logic                      mem_valid,
   output logic [AW-1:0]             mem_addr,
   output logic [DW-1:0]             mem_data,
   input  logic                      mem_ready,
   output logic                      busy,
   output logic                      done,
   output logic                      wb_strobe,
   output logic [AW-1:0]             base_new,
   output logic                      err,
   output logic                      push_alias,
   output logic                      base_unk
);
   localparam int IW     = $clog2(NREG);
   localparam int CW     = $clog2(NREG + 1);
   localparam int PC_IDX = NREG - 1;
   localparam int BSH    = $clog2(DW / 8);
   localparam logic [AW-1:0] STEP = AW'(DW / 8);

   if (NREG != (1 << IW)) begin : g_bad_nreg
      $error("NREG must be a power of two");
   end
   if ((DW % 8) != 0 || DW < 8) begin : g_bad_dw
      $error("DW must be a whole number of bytes");
   end
   if (SP_IDX >= PC_IDX || SP_IDX < 0) begin : g_bad_sp
      $error("SP_IDX must lie below the program counter index");
   end

   // request decode
   logic [CW-1:0] cnt_in;
   logic [IW-1:0] low_in;
   stmd_chk_t     chk;
   logic [AW-1:0] first_addr;

   stmd_popcnt #(.N(NREG), .CW(CW)) u_cnt (.vec(mask), .cnt(cnt_in));
   stmd_lsb_pick #(.N(NREG), .IW(IW)) u_low (.vec(mask), .idx(low_in));
   stmd_legal #(
      .NREG(NREG), .IW(IW), .CW(CW), .SP_IDX(SP_IDX), .ENABLE_COMPACT(ENABLE_COMPACT)
   ) u_legal (
      .mask(mask), .base_idx(base_idx), .wb(wb_en), .compact(compact),
      .cnt(cnt_in), .low_idx(low_in), .chk(chk)
   );

   assign first_addr = base_val - (AW'(cnt_in) << BSH);

   // sequencing state
   logic            busy_q, done_q, wbs_q, err_q, push_q, unk_en_q, wb_q;
   logic [NREG-1:0] rem_q;
   logic [AW-1:0]   addr_q, base_new_q;
   logic [IW-1:0]   bidx_q;
   logic [IW-1:0]   cur_idx;
   logic [NREG-1:0] cur_oh, rem_next;
   logic            go, acc, last, is_pc, is_unk;

   stmd_lsb_pick #(.N(NREG), .IW(IW)) u_cur (.vec(rem_q), .idx(cur_idx));

   assign cur_oh   = NREG'(1) << cur_idx;
   assign rem_next = rem_q & ~cur_oh;
   assign last     = (rem_next == '0);
   assign go       = start && !busy_q;
   assign acc      = busy_q && mem_ready;
   assign is_pc    = (cur_idx == IW'(PC_IDX));
   assign is_unk   = unk_en_q && (cur_idx == bidx_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         done_q     <= 1'b0;
         wbs_q      <= 1'b0;
         err_q      <= 1'b0;
         push_q     <= 1'b0;
         unk_en_q   <= 1'b0;
         wb_q       <= 1'b0;
         rem_q      <= '0;
         addr_q     <= '0;
         base_new_q <= '0;
         bidx_q     <= '0;
      end else begin
         done_q <= 1'b0;
         wbs_q  <= 1'b0;
         err_q  <= 1'b0;
         if (go) begin
            if (chk.illegal) begin
               err_q  <= 1'b1;
               push_q <= 1'b0;
            end else begin
               busy_q     <= 1'b1;
               rem_q      <= mask;
               addr_q     <= first_addr;
               base_new_q <= first_addr;
               unk_en_q   <= chk.unk_en;
               bidx_q     <= base_idx;
               wb_q       <= wb_en;
               push_q     <= chk.push;
            end
         end else if (acc) begin
            rem_q  <= rem_next;
            addr_q <= addr_q + STEP;
            if (last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               wbs_q  <= wb_q;
            end
         end
      end
   end

   assign rf_raddr   = cur_idx;
   assign mem_valid  = busy_q;
   assign mem_addr   = addr_q;
   assign mem_data   = is_pc ? pc_store_val : (is_unk ? UNK_WORD : rf_rdata);
   assign base_unk   = busy_q && is_unk;
   assign busy       = busy_q;
   assign done       = done_q;
   assign wb_strobe  = wbs_q;
   assign base_new   = base_new_q;
   assign err        = err_q;
   assign push_alias = push_q;

   // checks beside the logic they guard
   assert_first_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !chk.illegal) |=>
         (mem_valid && mem_addr == base_new));

   assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready) |=> (!busy || mem_addr == $past(mem_addr) + STEP));

   assert_wb_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wb_strobe |-> (done && !busy));

   assert_pc_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready && rf_raddr == IW'(PC_IDX)) |=> (!busy && done));

   assert_unk_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      base_unk |-> (mem_valid && mem_data == UNK_WORD));

   assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!busy && !mem_valid && !done && !wb_strobe));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> $stable(base_new));

   assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));
endmodule

// File: tb/stm_desc_seq_test.sv
`timescale 1ns/1ps
module stm_desc_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] mask = '0;
   logic [3:0]  base_idx = '0;
   logic        wb_en = 1'b0;
   logic        compact = 1'b0;
   logic [31:0] base_val = '0;
   logic [31:0] pc_store_val = '0;
   logic [3:0]  rf_raddr;
   logic [31:0] rf_rdata;
   logic        mem_valid;
   logic [31:0] mem_addr;
   logic [31:0] mem_data;
   logic        mem_ready = 1'b0;
   logic        busy, done, wb_strobe, err, push_alias, base_unk;
   logic [31:0] base_new;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 1'b0;

   localparam logic [31:0] UNK = 32'hBAD0_BAD0;

   always #4 clk = ~clk;

   function automatic logic [31:0] rfv(input logic [3:0] i);
      return 32'hC0DE_0000 + 32'(i) * 32'h0000_0111;
   endfunction

   assign rf_rdata = rfv(rf_raddr);

   stm_desc_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mask(mask), .base_idx(base_idx),
      .wb_en(wb_en), .compact(compact), .base_val(base_val), .pc_store_val(pc_store_val),
      .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .mem_valid(mem_valid), .mem_addr(mem_addr),
      .mem_data(mem_data), .mem_ready(mem_ready), .busy(busy), .done(done),
      .wb_strobe(wb_strobe), .base_new(base_new), .err(err), .push_alias(push_alias),
      .base_unk(base_unk)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic run_op(input logic [15:0] m, input logic [3:0] bi, input logic w,
                         input logic cp, input logic [31:0] bv, input logic [31:0] pv,
                         input bit stall, input bit poke);
      int cnt;
      int low;
      int nexp;
      int k;
      bit ill, push, pend;
      logic [3:0] lst [16];
      logic [31:0] first;
      cnt = $countones(m);
      ill = (m == 16'h0) || (bi == 4'd15);
      if (cp) ill = ill || (cnt < 2) || m[13] || m[15] || (w && m[bi]);
      push = !ill && w && (bi == 4'd13) && (cnt > 1);
      low = 16;
      nexp = 0;
      for (int i = 0; i < 16; i++) begin
         if (m[i]) begin
            lst[nexp] = 4'(i);
            nexp++;
            if (low == 16) low = i;
         end
      end
      first = bv - 32'(4 * cnt);

      @(negedge clk);
      mask = m; base_idx = bi; wb_en = w; compact = cp; base_val = bv; pc_store_val = pv;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (ill) begin
         chk(err == 1'b1, cp ? "R7 err pulse" : "R6 err pulse", 32'(err), 32'h1);
         chk(!busy && !mem_valid, "R6 no traffic", {busy, mem_valid}, 32'h0);
         chk(push_alias == 1'b0, "R8 no push on error", 32'(push_alias), 32'h0);
         @(negedge clk);
         chk(!err && !mem_valid && !done && !wb_strobe, "R6 one-cycle err",
             {err, mem_valid, done, wb_strobe}, 32'h0);
         return;
      end
      chk(busy == 1'b1, "R9 busy after start", 32'(busy), 32'h1);
      chk(base_new == first, "R1 base_new", base_new, first);
      k = 0;
      pend = 1'b0;
      for (int c = 0; c < 200; c++) begin
         if (poke && c == 0) begin
            mask = 16'h00F0; base_idx = 4'd2; wb_en = 1'b1; compact = 1'b0;
            base_val = 32'h0000_4000; start = 1'b1;
         end else begin
            start = 1'b0;
         end
         if (pend) chk(done == 1'b1, "R9 done after last write", 32'(done), 32'h1);
         if (done) begin
            chk(k == nexp, "R2 write count", 32'(k), 32'(nexp));
            chk(wb_strobe == w, "R3 wb strobe", 32'(wb_strobe), 32'(w));
            if (w) chk(base_new == first, "R3 base_new", base_new, first);
            chk(push_alias == push, "R8 push alias", 32'(push_alias), 32'(push));
            chk(!busy && !mem_valid, "R9 idle at done", {busy, mem_valid}, 32'h0);
            break;
         end
         chk(!wb_strobe, "R3 no strobe before done", 32'(wb_strobe), 32'h0);
         if (mem_valid) begin
            if (k >= nexp) begin
               chk(1'b0, "R2 extra write", 32'(k), 32'(nexp));
            end else begin
               logic [31:0] ea, ed;
               bit eu;
               ea = first + 32'(4 * k);
               eu = !cp && w && (lst[k] == bi) && (int'(bi) != low);
               if (lst[k] == 4'd15) ed = pv;
               else if (eu) ed = UNK;
               else ed = rfv(lst[k]);
               chk(mem_addr == ea, k == 0 ? "R1 first addr" : "R2 addr", mem_addr, ea);
               chk(mem_data == ed, lst[k] == 4'd15 ? "R4 pc data" : (eu ? "R5 placeholder" : "R2 data"),
                   mem_data, ed);
               chk(base_unk == eu, "R5 base_unk", 32'(base_unk), 32'(eu));
               chk(push_alias == push, "R8 push while busy", 32'(push_alias), 32'(push));
            end
            mem_ready = stall ? ((c % 3) != 0) : 1'b1;
            if (mem_ready) k++;
            pend = mem_ready && (k == nexp);
         end else begin
            chk(1'b0, "R9 busy without write", 32'(mem_valid), 32'h1);
            pend = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      mem_ready = 1'b0;
      for (int j = 0; j < 3; j++) begin
         @(negedge clk);
         chk(!mem_valid && !busy && !done, poke ? "R10 start ignored" : "R9 stays idle",
             {mem_valid, busy, done}, 32'h0);
      end
   endtask

   logic [15:0] pats [10] = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF, 16'h2000,
                              16'h5FFF, 16'h4003, 16'hA5A5, 16'h1234, 16'h8421};

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !mem_valid && !done && !err && !wb_strobe, "R9 reset state",
          {busy, mem_valid, done, err, wb_strobe}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !mem_valid, "R9 idle after reset", {busy, mem_valid}, 32'h0);

      for (int p = 0; p < 10; p++) begin
         for (int b = 0; b < 16; b++) begin
            for (int w = 0; w < 2; w++) begin
               for (int cp = 0; cp < 2; cp++) begin
                  run_op(pats[p], 4'(b), 1'(w), 1'(cp),
                         32'h0001_0000 + 32'(b * 256 + p * 16),
                         32'hFEED_0000 + 32'(p), 1'((p + b) % 2), 1'b0);
               end
            end
         end
      end
      // single registers: every bit, wrap-around base, stall or not
      for (int i = 0; i < 16; i++) begin
         run_op(16'h1 << i, 4'd13, 1'b1, 1'b0, 32'h0000_0002, 32'h1357_9BDF, 1'(i % 2), 1'b0);
      end
      // start arriving while the only write is being accepted
      for (int i = 0; i < 15; i++) begin
         run_op(16'h1 << i, 4'd0, 1'(i % 2), 1'b0, 32'h0000_8000, 32'h2468_ACE0, 1'b0, 1'b1);
      end
      // start while a long stalled sequence runs
      run_op(16'hFFFF, 4'd13, 1'b1, 1'b0, 32'h0000_9000, 32'hAAAA_5555, 1'b1, 1'b1);
      run_op(16'h7FFF, 4'd13, 1'b1, 1'b1, 32'h0000_9000, 32'hAAAA_5555, 1'b0, 1'b1);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule